// File: doc/BRIEF.md
# Fan Control Register Target on a Two-Wire Serial Bus

This block is a two-wire serial bus target (I2C-compatible, standard addressing only) that answers at one 7-bit device address set when the block is built. A host sets a register pointer with the first byte after a write address. Each later byte in the same transfer is written to the register the pointer selects. Reads return bytes from the pointer onward. The pointer advances by one after every data byte, in either direction. The block does not stretch the clock and does not arbitrate. SDA is modelled as an open-drain pin: the block sees the line level on `sda_i`, and `sda_oe` pulls the line low while it is high. SCL is an input only.

Two registers sit behind the bus. Register 0x00 is the fan control byte, and bit 7 of it turns the fan on. Register 0x01 behaves differently in each direction. A write sets the PWM duty in percent. A read returns the fan speed in revolutions per second, counted from the tachometer input over a fixed window. The PWM output runs a 100-step period, and each step lasts a set number of clock cycles.

Top module: `fan_ctrl_i2c_target`

## Requirements
- R1: The block acknowledges an address byte whose upper seven bits equal DEV_ADDR (default 0x74) by pulling SDA low during the ninth clock. The LSB of that byte selects the direction, with 0 for write and 1 for read.
- R2: An address byte whose seven address bits differ from DEV_ADDR is not acknowledged. The bytes that follow it, up to the next start or stop, change no register.
- R3: In a write transfer, the first data byte loads the register pointer and each later byte is written at the pointer. The pointer increments after every written byte and after every byte read.
- R4: A write to register 0x00 stores the whole byte, which register 0x00 then reads back. Bit 7 of the stored byte enables the fan.
- R5: A write to register 0x01 sets the duty in percent, and any value above 100 is stored as 100. After reset the duty is 80.
- R6: A read of register 0x01 returns the latched tachometer count. It never returns the duty setting.
- R7: While the fan is enabled, `pwm_o` repeats every 100*STEP_DIV cycles and is high for duty*STEP_DIV cycles of each period. While the fan is disabled, `pwm_o` stays low.
- R8: Rising edges on `tach_i` are counted over windows of WIN_CYCLES clock cycles. The count saturates at 255 and is latched into the readable register at the end of each window.
- R9: Reads of any register address other than 0x00 and 0x01 return 0x00, and writes to those addresses have no effect.
- R10: After reset the control byte is 0x00, the speed reading is 0, `pwm_o` is low and `sda_oe` is low.
- R11: The register pointer keeps its value across a repeated start, so a write of the pointer followed by a read transfer returns the register that was selected.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | Level of the serial clock line |
| sda_i | input | 1 | Level of the serial data line |
| sda_oe | output | 1 | When high, pull the data line low |
| tach_i | input | 1 | Fan tachometer pulse input |
| pwm_o | output | 1 | Fan PWM drive |

## Verification
The bench drives a bus master at the pins and goes after the corners where a mistake stays hidden during normal traffic. It sends an address that is one bit off and then keeps sending data. A decoder that compares too few bits, or keeps listening after the mismatch, would acknowledge it or take a write. It writes duty values of 0, 100 and 150. An off-by-one compare in the generator would leave a sliver of high time at 0 or a low step at 100, and a missing clamp would keep 150 and run at the wrong level. It reads register 0x01 while the duty and the speed hold different values, which exposes any muxing of the duty onto the read path. It drives tachometer rates far above 255 per window and with no pulses at all, so a counter that wraps instead of saturating, or one that never clears between windows, returns the wrong number. Burst writes and reads across both registers and into unmapped space show whether the pointer advances once per byte.

// File: rtl/fan_i2c_pkg.sv
package fan_i2c_pkg;
  localparam int unsigned BYTE_W     = 8;
  localparam int unsigned PWM_STEPS  = 100;
  localparam int unsigned FAN_EN_BIT = 7;
  localparam logic [BYTE_W-1:0] REG_CTRL = 8'h00;
  localparam logic [BYTE_W-1:0] REG_FAN  = 8'h01;

  typedef enum logic [2:0] {
    T_IDLE,
    T_ADDR,
    T_ADDR_ACK,
    T_WBYTE,
    T_WACK,
    T_RBYTE,
    T_RACK
  } tgt_state_e;
endpackage

// File: rtl/fan_i2c_bus_target.sv
module fan_i2c_bus_target
  import fan_i2c_pkg::*;
#(
  parameter logic [6:0] DEV_ADDR    = 7'h74,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              scl_i,
  input  logic              sda_i,
  output logic              sda_oe,
  output logic              wr_en,
  output logic [BYTE_W-1:0] wr_addr,
  output logic [BYTE_W-1:0] wr_data,
  output logic [BYTE_W-1:0] rd_addr,
  input  logic [BYTE_W-1:0] rd_data
);
  localparam int unsigned CNT_W = $clog2(BYTE_W + 1);
  localparam logic [CNT_W-1:0] FULL = CNT_W'(BYTE_W);

  logic [SYNC_STAGES-1:0] scl_sync, sda_sync;
  logic scl_d, sda_d, scl_s, sda_s;
  logic scl_rise, scl_fall, bus_start, bus_stop;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_sync <= '1;
      sda_sync <= '1;
      scl_d    <= 1'b1;
      sda_d    <= 1'b1;
    end else begin
      scl_sync <= {scl_sync[SYNC_STAGES-2:0], scl_i};
      sda_sync <= {sda_sync[SYNC_STAGES-2:0], sda_i};
      scl_d    <= scl_sync[SYNC_STAGES-1];
      sda_d    <= sda_sync[SYNC_STAGES-1];
    end
  end

  assign scl_s     = scl_sync[SYNC_STAGES-1];
  assign sda_s     = sda_sync[SYNC_STAGES-1];
  assign scl_rise  = scl_s & ~scl_d;
  assign scl_fall  = ~scl_s & scl_d;
  assign bus_start = scl_s & scl_d & sda_d & ~sda_s;
  assign bus_stop  = scl_s & scl_d & ~sda_d & sda_s;

  tgt_state_e        state;
  logic [CNT_W-1:0]  bit_cnt;
  logic [BYTE_W-1:0] shreg;
  logic [BYTE_W-1:0] ptr_q;
  logic              rw_q;
  logic              ptr_pending;
  logic              nack_q;

  assign rd_addr = ptr_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state       <= T_IDLE;
      bit_cnt     <= '0;
      shreg       <= '0;
      ptr_q       <= '0;
      rw_q        <= 1'b0;
      ptr_pending <= 1'b0;
      nack_q      <= 1'b0;
      sda_oe      <= 1'b0;
      wr_en       <= 1'b0;
      wr_addr     <= '0;
      wr_data     <= '0;
    end else begin
      wr_en <= 1'b0;
      if (bus_stop) begin
        state  <= T_IDLE;
        sda_oe <= 1'b0;
      end else if (bus_start) begin
        // R11: pointer is left untouched by a (repeated) start
        state   <= T_ADDR;
        bit_cnt <= '0;
        sda_oe  <= 1'b0;
      end else begin
        unique case (state)
          T_IDLE: ;
          T_ADDR: begin
            if (scl_rise) begin
              shreg   <= {shreg[BYTE_W-2:0], sda_s};
              bit_cnt <= bit_cnt + 1'b1;
            end else if (scl_fall && bit_cnt == FULL) begin
              // R1 / R2: acknowledge only a matching address
              if (shreg[BYTE_W-1:1] == DEV_ADDR) begin
                sda_oe <= 1'b1;
                rw_q   <= shreg[0];
                state  <= T_ADDR_ACK;
              end else begin
                state <= T_IDLE;
              end
            end
          end
          T_ADDR_ACK: begin
            if (scl_fall) begin
              bit_cnt <= '0;
              if (rw_q) begin
                shreg  <= rd_data;
                sda_oe <= ~rd_data[BYTE_W-1];
                state  <= T_RBYTE;
              end else begin
                sda_oe      <= 1'b0;
                ptr_pending <= 1'b1;
                state       <= T_WBYTE;
              end
            end
          end
          T_WBYTE: begin
            if (scl_rise) begin
              shreg   <= {shreg[BYTE_W-2:0], sda_s};
              bit_cnt <= bit_cnt + 1'b1;
            end else if (scl_fall && bit_cnt == FULL) begin
              sda_oe <= 1'b1;
              state  <= T_WACK;
              // R3: first byte is the pointer, later bytes are data
              if (ptr_pending) begin
                ptr_q       <= shreg;
                ptr_pending <= 1'b0;
              end else begin
                wr_en   <= 1'b1;
                wr_addr <= ptr_q;
                wr_data <= shreg;
                ptr_q   <= ptr_q + 1'b1;
              end
            end
          end
          T_WACK: begin
            if (scl_fall) begin
              sda_oe  <= 1'b0;
              bit_cnt <= '0;
              state   <= T_WBYTE;
            end
          end
          T_RBYTE: begin
            if (scl_rise) begin
              bit_cnt <= bit_cnt + 1'b1;
            end else if (scl_fall) begin
              if (bit_cnt == FULL) begin
                sda_oe <= 1'b0;
                state  <= T_RACK;
              end else begin
                shreg  <= {shreg[BYTE_W-2:0], 1'b0};
                sda_oe <= ~shreg[BYTE_W-2];
              end
            end
          end
          T_RACK: begin
            if (scl_rise) begin
              nack_q <= sda_s;
              ptr_q  <= ptr_q + 1'b1;
            end else if (scl_fall) begin
              if (nack_q) begin
                state <= T_IDLE;
              end else begin
                shreg   <= rd_data;
                sda_oe  <= ~rd_data[BYTE_W-1];
                bit_cnt <= '0;
                state   <= T_RBYTE;
              end
            end
          end
          default: state <= T_IDLE;
        endcase
      end
    end
  end
endmodule

// File: rtl/fan_reg_bank.sv
module fan_reg_bank
  import fan_i2c_pkg::*;
#(
  parameter int unsigned DUTY_RESET = 80,
  parameter int unsigned DUTY_MAX   = 100
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [BYTE_W-1:0] wr_addr,
  input  logic [BYTE_W-1:0] wr_data,
  input  logic [BYTE_W-1:0] rd_addr,
  output logic [BYTE_W-1:0] rd_data,
  input  logic [BYTE_W-1:0] speed,
  output logic              fan_en,
  output logic [BYTE_W-1:0] duty
);
  localparam logic [BYTE_W-1:0] DMAX = BYTE_W'(DUTY_MAX);

  logic [BYTE_W-1:0] ctrl_q, duty_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q <= '0;
      duty_q <= BYTE_W'(DUTY_RESET);
    end else if (wr_en) begin
      unique case (wr_addr)
        REG_CTRL: ctrl_q <= wr_data;                              // R4
        REG_FAN:  duty_q <= (wr_data > DMAX) ? DMAX : wr_data;    // R5
        default:  ;                                               // R9
      endcase
    end
  end

  always_comb begin
    unique case (rd_addr)
      REG_CTRL: rd_data = ctrl_q;
      REG_FAN:  rd_data = speed;     // R6
      default:  rd_data = '0;
    endcase
  end

  assign fan_en = ctrl_q[FAN_EN_BIT];
  assign duty   = duty_q;
endmodule

// File: rtl/fan_pwm_gen.sv
module fan_pwm_gen
  import fan_i2c_pkg::*;
#(
  parameter int unsigned STEP_DIV = 40
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              fan_en,
  input  logic [BYTE_W-1:0] duty,
  output logic              pwm_o
);
  localparam int unsigned SW = $clog2(PWM_STEPS);
  localparam int unsigned DW = (STEP_DIV > 1) ? $clog2(STEP_DIV) : 1;

  logic step_tick;

  generate
    if (STEP_DIV > 1) begin : g_div
      logic [DW-1:0] div_q;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                            div_q <= '0;
        else if (div_q == DW'(STEP_DIV - 1))   div_q <= '0;
        else                                   div_q <= div_q + 1'b1;
      end
      assign step_tick = (div_q == DW'(STEP_DIV - 1));
    end else begin : g_nodiv
      assign step_tick = 1'b1;
    end
  endgenerate

  logic [SW-1:0] step_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      step_q <= '0;
      pwm_o  <= 1'b0;
    end else begin
      if (step_tick) begin
        if (step_q == SW'(PWM_STEPS - 1)) step_q <= '0;
        else                              step_q <= step_q + 1'b1;
      end
      // R7: high while the step is below the duty, low when disabled
      pwm_o <= fan_en && (BYTE_W'(step_q) < duty);
    end
  end
endmodule

// File: rtl/fan_tach_meter.sv
module fan_tach_meter
  import fan_i2c_pkg::*;
#(
  parameter int unsigned WIN_CYCLES  = 100_000_000,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tach_i,
  output logic [BYTE_W-1:0] speed
);
  localparam int unsigned WW = $clog2(WIN_CYCLES);

  logic [SYNC_STAGES-1:0] t_sync;
  logic t_d, t_edge, win_end;
  logic [WW-1:0]     win_q;
  logic [BYTE_W-1:0] cnt_q, cnt_next;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      t_sync <= '0;
      t_d    <= 1'b0;
    end else begin
      t_sync <= {t_sync[SYNC_STAGES-2:0], tach_i};
      t_d    <= t_sync[SYNC_STAGES-1];
    end
  end

  assign t_edge  = t_sync[SYNC_STAGES-1] & ~t_d;
  assign win_end = (win_q == WW'(WIN_CYCLES - 1));
  // R8: saturate instead of wrapping
  assign cnt_next = (t_edge && cnt_q != '1) ? cnt_q + 1'b1 : cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      win_q <= '0;
      cnt_q <= '0;
      speed <= '0;
    end else if (win_end) begin
      win_q <= '0;
      cnt_q <= '0;
      speed <= cnt_next;
    end else begin
      win_q <= win_q + 1'b1;
      cnt_q <= cnt_next;
    end
  end
endmodule

// File: rtl/fan_ctrl_i2c_target.sv
module fan_ctrl_i2c_target
  import fan_i2c_pkg::*;
#(
  parameter logic [6:0]  DEV_ADDR    = 7'h74,
  parameter int unsigned STEP_DIV    = 40,
  parameter int unsigned WIN_CYCLES  = 100_000_000,
  parameter int unsigned DUTY_RESET  = 80,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_i,
  input  logic sda_i,
  output logic sda_oe,
  input  logic tach_i,
  output logic pwm_o
);
  logic              wr_en;
  logic [BYTE_W-1:0] wr_addr, wr_data, rd_addr, rd_data;
  logic [BYTE_W-1:0] speed, duty;
  logic              fan_en;

  fan_i2c_bus_target #(.DEV_ADDR(DEV_ADDR), .SYNC_STAGES(SYNC_STAGES)) u_bus (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_i), .sda_i(sda_i), .sda_oe(sda_oe),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_addr(rd_addr), .rd_data(rd_data)
  );

  fan_reg_bank #(.DUTY_RESET(DUTY_RESET), .DUTY_MAX(PWM_STEPS)) u_regs (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_addr(rd_addr), .rd_data(rd_data), .speed(speed), .fan_en(fan_en), .duty(duty)
  );

  fan_pwm_gen #(.STEP_DIV(STEP_DIV)) u_pwm (
    .clk(clk), .rst_n(rst_n), .fan_en(fan_en), .duty(duty), .pwm_o(pwm_o)
  );

  fan_tach_meter #(.WIN_CYCLES(WIN_CYCLES), .SYNC_STAGES(SYNC_STAGES)) u_tach (
    .clk(clk), .rst_n(rst_n), .tach_i(tach_i), .speed(speed)
  );
endmodule

// File: rtl/fan_ctrl_chk.sv
module fan_ctrl_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       scl_i,
  input logic       sda_oe,
  input logic       pwm_o,
  input logic       fan_en,
  input logic [7:0] duty,
  input logic       wr_en,
  input logic [7:0] wr_addr,
  input logic [7:0] wr_data
);
  // R7
  pwm_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !fan_en |=> !pwm_o);

  // R5
  duty_clamp_chk: assert property (@(posedge clk) disable iff (!rst_n)
    duty <= 8'd100);

  // R3
  wr_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> !wr_en);

  // R4
  en_bit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_addr == 8'h00) |=> (fan_en == $past(wr_data[7])));

  // R1
  ack_drive_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sda_oe) |-> !scl_i);
endmodule

bind fan_ctrl_i2c_target fan_ctrl_chk u_chk (
  .clk(clk), .rst_n(rst_n), .scl_i(scl_i), .sda_oe(sda_oe), .pwm_o(pwm_o),
  .fan_en(fan_en), .duty(duty), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data)
);

// File: tb/sim_fan_ctrl_i2c_target.sv
`timescale 1ns/1ps
module sim_fan_ctrl_i2c_target;
  localparam logic [6:0] ADDR = 7'h74;
  localparam int Q   = 10;
  localparam int WIN = 2000;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic m_scl = 1'b1;
  logic m_sda = 1'b1;
  logic tach = 1'b0;
  int   tach_per = 0;
  logic sda_oe, pwm_o;
  wire  sda_line = m_sda & ~sda_oe;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  fan_ctrl_i2c_target #(.DEV_ADDR(ADDR), .STEP_DIV(1), .WIN_CYCLES(WIN)) u0 (
    .clk(clk), .rst_n(rst_n), .scl_i(m_scl), .sda_i(sda_line), .sda_oe(sda_oe),
    .tach_i(tach), .pwm_o(pwm_o)
  );

  always begin
    if (tach_per == 0) begin
      tach = 1'b0;
      @(negedge clk);
    end else begin
      tach = 1'b1;
      repeat (tach_per / 2) @(negedge clk);
      tach = 1'b0;
      repeat (tach_per - tach_per / 2) @(negedge clk);
    end
  end

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic hold();
    repeat (Q) @(negedge clk);
  endtask

  task automatic i2c_start();
    m_sda = 1'b1; hold(); m_scl = 1'b1; hold(); m_sda = 1'b0; hold(); m_scl = 1'b0; hold();
  endtask

  task automatic i2c_stop();
    m_sda = 1'b0; hold(); m_scl = 1'b1; hold(); m_sda = 1'b1; hold();
  endtask

  task automatic i2c_tx(input logic [7:0] b, output logic ack);
    for (int i = 7; i >= 0; i--) begin
      m_sda = b[i]; hold(); m_scl = 1'b1; hold(); hold(); m_scl = 1'b0; hold();
    end
    m_sda = 1'b1; hold(); m_scl = 1'b1; hold(); ack = ~sda_line; hold(); m_scl = 1'b0; hold();
  endtask

  task automatic i2c_rx(input logic mack, output logic [7:0] b);
    for (int i = 7; i >= 0; i--) begin
      m_sda = 1'b1; hold(); m_scl = 1'b1; hold(); b[i] = sda_line; hold(); m_scl = 1'b0; hold();
    end
    m_sda = ~mack; hold(); m_scl = 1'b1; hold(); hold(); m_scl = 1'b0; hold(); m_sda = 1'b1;
  endtask

  task automatic wr_regs(input logic [7:0] ptr, input int n, input logic [7:0] d0,
                         input logic [7:0] d1, output logic ok);
    logic a0, a1, a2, a3;
    i2c_start();
    i2c_tx({ADDR, 1'b0}, a0);
    i2c_tx(ptr, a1);
    i2c_tx(d0, a2);
    a3 = 1'b1;
    if (n > 1) i2c_tx(d1, a3);
    i2c_stop();
    ok = a0 & a1 & a2 & a3;
  endtask

  task automatic rd_regs(input logic [7:0] ptr, input int n, output logic [7:0] d0,
                         output logic [7:0] d1, output logic ok);
    logic a0, a1, a2;
    i2c_start();
    i2c_tx({ADDR, 1'b0}, a0);
    i2c_tx(ptr, a1);
    i2c_start();
    i2c_tx({ADDR, 1'b1}, a2);
    d1 = 8'h00;
    if (n > 1) begin
      i2c_rx(1'b1, d0);
      i2c_rx(1'b0, d1);
    end else begin
      i2c_rx(1'b0, d0);
    end
    i2c_stop();
    ok = a0 & a1 & a2;
  endtask

  task automatic pwm_high(output int n);
    repeat (250) @(negedge clk);
    n = 0;
    for (int i = 0; i < 100; i++) begin
      @(negedge clk);
      n += int'(pwm_o);
    end
  endtask

  task automatic t_reset();
    logic [7:0] d0, d1; logic ok; int hi;
    chk("R10 sda_oe after reset", int'(sda_oe), 0);
    pwm_high(hi);
    chk("R10 pwm low after reset", hi, 0);
    rd_regs(8'h00, 2, d0, d1, ok);
    chk("R1 ack on matching address", int'(ok), 1);
    chk("R10 control byte after reset", int'(d0), 0);
    chk("R10 speed after reset", int'(d1), 0);
  endtask

  task automatic t_wrong_addr();
    logic a0, a1, a2; logic [7:0] d0, d1; logic ok; int hi;
    i2c_start();
    i2c_tx({7'h75, 1'b0}, a0);
    i2c_tx(8'h00, a1);
    i2c_tx(8'h80, a2);
    i2c_stop();
    chk("R2 nack on other address", int'(a0), 0);
    chk("R2 no ack on following bytes", int'(a1 | a2), 0);
    rd_regs(8'h00, 1, d0, d1, ok);
    chk("R2 control unchanged", int'(d0), 0);
    pwm_high(hi);
    chk("R2 pwm stays low", hi, 0);
  endtask

  task automatic t_enable();
    logic [7:0] d0, d1; logic ok; int hi;
    wr_regs(8'h00, 1, 8'h80, 8'h00, ok);
    chk("R1 write acked", int'(ok), 1);
    rd_regs(8'h00, 1, d0, d1, ok);
    chk("R4 control readback", int'(d0), 8'h80);
    pwm_high(hi);
    chk("R5 default duty 80", hi, 80);
  endtask

  task automatic t_duty();
    logic [7:0] d0, d1; logic ok; int hi;
    wr_regs(8'h01, 1, 8'd25, 8'h00, ok);
    pwm_high(hi);
    chk("R7 duty 25", hi, 25);
    wr_regs(8'h01, 1, 8'd0, 8'h00, ok);
    pwm_high(hi);
    chk("R7 duty 0", hi, 0);
    wr_regs(8'h01, 1, 8'd100, 8'h00, ok);
    pwm_high(hi);
    chk("R7 duty 100", hi, 100);
    wr_regs(8'h01, 1, 8'd150, 8'h00, ok);
    pwm_high(hi);
    chk("R5 duty 150 clamped", hi, 100);
    rd_regs(8'h01, 1, d0, d1, ok);
    chk("R6 reg1 read is speed not duty", int'(d0), 0);
  endtask

  task automatic t_disable();
    logic [7:0] d0, d1; logic ok; int hi;
    wr_regs(8'h00, 1, 8'h7F, 8'h00, ok);
    pwm_high(hi);
    chk("R7 bit7 clear gives low pwm", hi, 0);
    rd_regs(8'h00, 1, d0, d1, ok);
    chk("R4 low bits stored", int'(d0), 8'h7F);
  endtask

  task automatic t_burst();
    logic [7:0] d0, d1; logic ok; int hi;
    wr_regs(8'h00, 2, 8'h81, 8'd50, ok);
    chk("R3 burst write acked", int'(ok), 1);
    pwm_high(hi);
    chk("R3 second byte went to duty", hi, 50);
    rd_regs(8'h00, 2, d0, d1, ok);
    chk("R3 burst read byte0", int'(d0), 8'h81);
    chk("R3 burst read byte1 speed", int'(d1), 0);
  endtask

  task automatic t_unmapped();
    logic [7:0] d0, d1; logic ok; int hi;
    wr_regs(8'h01, 2, 8'd30, 8'hFF, ok);
    pwm_high(hi);
    chk("R9 duty 30 before unmapped byte", hi, 30);
    wr_regs(8'h02, 1, 8'h00, 8'h00, ok);
    rd_regs(8'h02, 1, d0, d1, ok);
    chk("R9 unmapped reads zero", int'(d0), 0);
    rd_regs(8'h00, 1, d0, d1, ok);
    chk("R9 control untouched", int'(d0), 8'h81);
    pwm_high(hi);
    chk("R9 pwm untouched", hi, 30);
  endtask

  task automatic t_tach();
    logic [7:0] d0, d1; logic ok;
    tach_per = 25;
    repeat (2 * WIN + 200) @(negedge clk);
    rd_regs(8'h01, 1, d0, d1, ok);
    chk("R11 R6 R8 speed 80 per window", int'(d0), 80);
    rd_regs(8'h00, 2, d0, d1, ok);
    chk("R3 read increments into speed", int'(d1), 80);
    tach_per = 4;
    repeat (2 * WIN + 200) @(negedge clk);
    rd_regs(8'h01, 1, d0, d1, ok);
    chk("R8 saturates at 255", int'(d0), 255);
    tach_per = 0;
    repeat (2 * WIN + 200) @(negedge clk);
    rd_regs(8'h01, 1, d0, d1, ok);
    chk("R8 no pulses gives 0", int'(d0), 0);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  endtask

  initial begin
    repeat (10) @(negedge clk);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);
    t_reset();
    t_wrong_addr();
    t_enable();
    t_duty();
    t_disable();
    t_burst();
    t_unmapped();
    t_tach();
    finish_run();
  end

  initial begin
    repeat (190000) @(posedge clk);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
    finish_run();
  end
endmodule